// File: doc/BRIEF.md
# Two-Register Power Controller Configuration Slave (I2C)

This block is an I2C slave that holds the configuration of a dual-channel power controller in two small system registers. A write sends one data byte after the device address. Bit 7 of that byte steers the byte into register A (0) or register B (1), and bits 5:0 carry the field data. A read returns register contents one byte at a time, most significant bit first. The first byte comes from the register last written. Each acknowledged byte switches to the other register, and a not-acknowledge ends the read. Bit 6 of every read byte carries live hardware status: the overload flag in the register A byte and the over-temperature flag in the register B byte.

The block decodes register A into the channel 1 controls: output-voltage code, tone output, current-limit selection, dynamic current limiting and channel enable. Bit 0 of register B enables channel 2. SCL and SDA are oversampled by the system clock through a two-flop synchronizer, so START and STOP are found by comparing consecutive samples. A power-good input holds the bus engine idle and both registers at zero while it is low.

Top module: `dual_sysreg_i2c`

## Requirements
- R1: After a START, the slave acknowledges an address byte whose upper seven bits equal the DEV_ADDR parameter, and it leaves SDA released during the acknowledge slot of any other address.
- R2: In a write byte, bit 7 selects the target register (0 = A, 1 = B) and bits 5:0 are stored in it. The other register keeps its contents.
- R3: Bit 6 of a written byte is discarded. In a read byte, bit 6 is the synchronized overload input for register A and the synchronized over-temperature input for register B.
- R4: A read byte is {1'b0, OLF, A[5:0]} for register A and {1'b1, OTF, B[5:0]} for register B, sent MSB first. The first byte comes from the register selected by the last write (A after reset). Each master ACK switches to the other register.
- R5: A master NACK after a read byte ends the read, and the slave keeps SDA released from then on.
- R6: While power-good is low, the slave does not acknowledge any address, never drives SDA, and holds both registers and the last-selected pointer at zero, so all control outputs are 0.
- R7: vsel_code is {A[0], A[1]} (the VSEL and LLC bits): 0 selects 13 V, 1 selects 14 V, 2 selects 18 V and 3 selects 19 V.
- R8: With A[2] = 0, tone_out follows tone_i. With A[2] = 1, tone_out is 1 whatever tone_i is.
- R9: ilim_hi equals A[3] (0 = 425 mA class, 1 = 775 mA class), and dyn_ilim equals A[4].
- R10: With A[5] = 0, ch1_en, tone_out, ilim_hi and dyn_ilim are 0 and vsel_code is 0, whatever the other fields hold. With A[5] = 1, ch1_en is 1.
- R11: ch2_en equals B[0] and does not depend on register A.
- R12: The status bits are captured when a read byte is loaded. A status change during that byte does not alter the byte being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Power-good; low holds the block idle and cleared |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| otf_i | input | 1 | Over-temperature status input |
| olf_i | input | 1 | Overload status input |
| tone_i | input | 1 | External tone input for channel 1 |
| vsel_code | output | 2 | Channel 1 voltage code (0:13 V, 1:14 V, 2:18 V, 3:19 V) |
| tone_out | output | 1 | Channel 1 tone enable |
| ilim_hi | output | 1 | Channel 1 high current-limit select |
| dyn_ilim | output | 1 | Channel 1 dynamic current limiting |
| ch1_en | output | 1 | Channel 1 power stages enable |
| ch2_en | output | 1 | Channel 2 power stages enable |

## Verification
The bench writes a byte with bit 6 set and reads it back. A design that stored that bit would return it in place of the live status flag. It reads three bytes in a row after a write to register B to catch a pointer that does not start at the last-written register or does not alternate. It changes the overload input in the middle of a read byte, which a design that muxes status straight onto the shift register would expose. It also writes all field bits with the channel enable clear, and it drops power-good both around an address byte and after configuration. A design that gates only ch1_en, or keeps its registers or pointer through power loss, would show it at the outputs or in the read order.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int BYTE_W  = 8;
  localparam int FIELD_W = 6;
  localparam int CNT_W   = $clog2(BYTE_W + 1);
  localparam int SYNC_W  = 5;

  // register A field positions (decoded by the output logic)
  localparam int A_VSEL = 0;
  localparam int A_LLC  = 1;
  localparam int A_TONE = 2;
  localparam int A_ISEL = 3;
  localparam int A_DCL  = 4;
  localparam int A_EN   = 5;
  // register B field positions
  localparam int B_EN   = 0;

  // positions inside the synchronizer vector
  localparam int SY_SCL = 0;
  localparam int SY_SDA = 1;
  localparam int SY_OTF = 2;
  localparam int SY_OLF = 3;
  localparam int SY_PWR = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_st_e;
endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int             W      = 1,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RST_V  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= RST_V;
          else        stg_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= RST_V;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/psr_i2c_engine.sv
module psr_i2c_engine
  import psr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h08
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_ok,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic [BYTE_W-1:0]  byte_a,
  input  logic [BYTE_W-1:0]  byte_b,
  input  logic               last_sel,
  output logic               wr_stb,
  output logic               wr_sel,
  output logic [FIELD_W-1:0] wr_fields,
  output logic               sda_oe
);
  logic              scl_q, sda_q;
  logic              scl_rise, scl_fall, start_det, stop_det;
  bus_st_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              ptr_q, ptr_d;
  logic              ack_q, ack_d;
  logic              oe_q, oe_d;
  logic [BYTE_W-1:0] first_byte, next_byte;
  logic              byte_done;

  // line history for edge and condition detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign byte_done = (cnt_q == CNT_W'(BYTE_W));

  assign first_byte = last_sel ? byte_b : byte_a;
  assign next_byte  = ptr_q    ? byte_a : byte_b;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    rw_d   = rw_q;
    ptr_d  = ptr_q;
    ack_d  = ack_q;
    oe_d   = oe_q;
    wr_stb = 1'b0;
    if (!pwr_ok) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_det) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && byte_done) begin
            if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
              st_d = ST_ADDR_ACK;
              oe_d = 1'b1;
              rw_d = sh_q[0];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              st_d  = ST_RD;
              ptr_d = last_sel;
              sh_d  = first_byte;
              oe_d  = ~first_byte[BYTE_W-1];
            end else begin
              st_d = ST_WR;
              oe_d = 1'b0;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && byte_done) begin
            st_d   = ST_WR_ACK;
            oe_d   = 1'b1;
            wr_stb = 1'b1;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            st_d  = ST_WR;
            oe_d  = 1'b0;
            cnt_d = '0;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (byte_done) begin
              st_d = ST_RD_ACK;
              oe_d = 1'b0;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            ack_d = ~sda_s;
          end else if (scl_fall) begin
            if (ack_q) begin
              st_d  = ST_RD;
              ptr_d = ~ptr_q;
              sh_d  = next_byte;
              oe_d  = ~next_byte[BYTE_W-1];
              cnt_d = '0;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      rw_q  <= 1'b0;
      ptr_q <= 1'b0;
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      rw_q  <= rw_d;
      ptr_q <= ptr_d;
      ack_q <= ack_d;
      oe_q  <= oe_d;
    end
  end

  assign sda_oe    = oe_q;
  assign wr_sel    = sh_q[BYTE_W-1];
  assign wr_fields = sh_q[FIELD_W-1:0];

  // R6
  pwr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (!sda_oe && st_q == ST_IDLE));

  // R1
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !start_det && !stop_det && st_q == ST_ADDR && scl_fall && byte_done
     && sh_q[BYTE_W-1:1] != DEV_ADDR) |=> (!sda_oe && st_q == ST_IDLE));

  // R5
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !start_det && !stop_det && st_q == ST_RD_ACK && scl_fall && !ack_q)
    |=> (!sda_oe && st_q == ST_IDLE));

  // R4
  sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_ok) && !$stable(sda_oe))
    |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));
endmodule

// File: rtl/psr_regbank.sv
module psr_regbank
  import psr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_ok,
  input  logic               wr_stb,
  input  logic               wr_sel,
  input  logic [FIELD_W-1:0] wr_fields,
  input  logic               otf_s,
  input  logic               olf_s,
  input  logic               tone_i,
  output logic [BYTE_W-1:0]  byte_a,
  output logic [BYTE_W-1:0]  byte_b,
  output logic               last_sel,
  output logic [1:0]         vsel_code,
  output logic               tone_out,
  output logic               ilim_hi,
  output logic               dyn_ilim,
  output logic               ch1_en,
  output logic               ch2_en
);
  logic [FIELD_W-1:0] ra_q, ra_d, rb_q, rb_d;
  logic               sel_q, sel_d;
  logic               a_wen, b_wen;

  assign a_wen = wr_stb & ~wr_sel;
  assign b_wen = wr_stb &  wr_sel;

  always_comb begin
    ra_d  = ra_q;
    rb_d  = rb_q;
    sel_d = sel_q;
    if (!pwr_ok) begin
      ra_d  = '0;
      rb_d  = '0;
      sel_d = 1'b0;
    end else begin
      if (a_wen) ra_d = wr_fields;
      if (b_wen) rb_d = wr_fields;
      if (wr_stb) sel_d = wr_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q  <= '0;
      rb_q  <= '0;
      sel_q <= 1'b0;
    end else begin
      ra_q  <= ra_d;
      rb_q  <= rb_d;
      sel_q <= sel_d;
    end
  end

  assign byte_a   = {1'b0, olf_s, ra_q};
  assign byte_b   = {1'b1, otf_s, rb_q};
  assign last_sel = sel_q;

  // channel 1 decode; every field is gated by the enable bit
  logic en1;
  assign en1       = ra_q[A_EN];
  assign ch1_en    = en1;
  assign vsel_code = en1 ? {ra_q[A_VSEL], ra_q[A_LLC]} : 2'b00;
  assign tone_out  = en1 & (ra_q[A_TONE] | tone_i);
  assign ilim_hi   = en1 & ra_q[A_ISEL];
  assign dyn_ilim  = en1 & ra_q[A_DCL];
  assign ch2_en    = rb_q[B_EN];

  // R6
  pwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (ra_q == '0 && rb_q == '0 && !last_sel));

  // R2
  wr_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && wr_stb && !wr_sel) |=> (ra_q == $past(wr_fields) && rb_q == $past(rb_q)));

  // R2
  wr_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && wr_stb && wr_sel) |=> (rb_q == $past(wr_fields) && ra_q == $past(ra_q)));
endmodule

// File: rtl/dual_sysreg_i2c.sv
module dual_sysreg_i2c
  import psr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h08,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       otf_i,
  input  logic       olf_i,
  input  logic       tone_i,
  output logic [1:0] vsel_code,
  output logic       tone_out,
  output logic       ilim_hi,
  output logic       dyn_ilim,
  output logic       ch1_en,
  output logic       ch2_en
);
  localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'((1 << SY_SCL) | (1 << SY_SDA));

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  logic [SYNC_W-1:0] raw_v, syn_v;
  assign raw_v[SY_SCL] = scl_i;
  assign raw_v[SY_SDA] = sda_i;
  assign raw_v[SY_OTF] = otf_i;
  assign raw_v[SY_OLF] = olf_i;
  assign raw_v[SY_PWR] = pwr_ok;

  psr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_V(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d_i   (raw_v),
    .q_o   (syn_v)
  );

  logic [BYTE_W-1:0]  byte_a, byte_b;
  logic               last_sel, wr_stb, wr_sel;
  logic [FIELD_W-1:0] wr_fields;

  psr_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk       (clk),
    .rst_n     (rst_sn),
    .pwr_ok    (syn_v[SY_PWR]),
    .scl_s     (syn_v[SY_SCL]),
    .sda_s     (syn_v[SY_SDA]),
    .byte_a    (byte_a),
    .byte_b    (byte_b),
    .last_sel  (last_sel),
    .wr_stb    (wr_stb),
    .wr_sel    (wr_sel),
    .wr_fields (wr_fields),
    .sda_oe    (sda_oe)
  );

  psr_regbank u_bank (
    .clk       (clk),
    .rst_n     (rst_sn),
    .pwr_ok    (syn_v[SY_PWR]),
    .wr_stb    (wr_stb),
    .wr_sel    (wr_sel),
    .wr_fields (wr_fields),
    .otf_s     (syn_v[SY_OTF]),
    .olf_s     (syn_v[SY_OLF]),
    .tone_i    (tone_i),
    .byte_a    (byte_a),
    .byte_b    (byte_b),
    .last_sel  (last_sel),
    .vsel_code (vsel_code),
    .tone_out  (tone_out),
    .ilim_hi   (ilim_hi),
    .dyn_ilim  (dyn_ilim),
    .ch1_en    (ch1_en),
    .ch2_en    (ch2_en)
  );

  // R10
  ch1_off_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !ch1_en |-> (!tone_out && vsel_code == 2'b00 && !ilim_hi && !dyn_ilim));
endmodule

// File: tb/tb_dual_sysreg_i2c.sv
module tb_dual_sysreg_i2c;
  localparam logic [6:0] ADDR = 7'h08;
  localparam logic [7:0] AW   = {ADDR, 1'b0};
  localparam logic [7:0] AR   = {ADDR, 1'b1};

  logic clk;
  logic rst_n, pwr_ok, scl_m, sda_m, otf, olf, tone;
  logic sda_oe, tone_out, ilim_hi, dyn_ilim, ch1_en, ch2_en;
  logic [1:0] vsel_code;
  logic sda_bus;
  int n_chk = 0;
  int n_fail = 0;

  assign sda_bus = sda_m & ~sda_oe;

  initial clk = 1'b0;
  always #2.5ns clk = ~clk;

  dual_sysreg_i2c #(.DEV_ADDR(ADDR)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .otf_i(otf), .olf_i(olf), .tone_i(tone),
    .vsel_code(vsel_code), .tone_out(tone_out), .ilim_hi(ilim_hi),
    .dyn_ilim(dyn_ilim), .ch1_en(ch1_en), .ch2_en(ch2_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    #40ns;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait(); qwait();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    b = sda_bus; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(x);
    ack = ~x;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(~give_ack);
  endtask

  task automatic write_reg(input logic [7:0] v, input string req);
    logic a;
    i2c_start();
    wr_byte(AW, a);
    check({req, " addr ack"}, a, 1'b1);
    wr_byte(v, a);
    check({req, " data ack"}, a, 1'b1);
    i2c_stop();
  endtask

  // R1 R6: wrong address and power loss give no acknowledge
  task automatic t_addr();
    logic a;
    i2c_start(); wr_byte(8'h22, a); i2c_stop();
    check("R1 wrong address nack", a, 1'b0);
    pwr_ok = 1'b0; repeat (10) @(negedge clk);
    i2c_start(); wr_byte(AW, a); i2c_stop();
    check("R6 no ack while power low", a, 1'b0);
    check("R6 sda released while power low", sda_oe, 1'b0);
    pwr_ok = 1'b1; repeat (10) @(negedge clk);
  endtask

  // R2 R7 R8 R9 R11: field decode after writes to both registers
  task automatic t_write();
    write_reg(8'h72, "R2 write A");
    check("R10 ch1 enabled", ch1_en, 1'b1);
    check("R7 code VSEL=0 LLC=1", vsel_code, 2'd1);
    check("R9 ilim low", ilim_hi, 1'b0);
    check("R9 dyn ilim", dyn_ilim, 1'b1);
    tone = 1'b1; #1ns;
    check("R8 tone follows input 1", tone_out, 1'b1);
    tone = 1'b0; #1ns;
    check("R8 tone follows input 0", tone_out, 1'b0);
    write_reg(8'hC1, "R2 write B");
    check("R11 ch2 enabled", ch2_en, 1'b1);
    check("R2 A kept after B write", {ch1_en, dyn_ilim, vsel_code}, 4'b1101);
  endtask

  // R3 R4 R5: alternating read with live status
  task automatic t_read();
    logic a;
    logic [7:0] v;
    otf = 1'b1; olf = 1'b0; repeat (10) @(negedge clk);
    i2c_start(); wr_byte(AR, a);
    check("R4 read addr ack", a, 1'b1);
    rd_byte(1'b1, v); check("R4 first byte from B with OTF", v, 8'hC1);
    rd_byte(1'b1, v); check("R3 A byte, bit6 write dropped", v, 8'h32);
    rd_byte(1'b0, v); check("R4 alternates back to B", v, 8'hC1);
    check("R5 sda released after nack", sda_oe, 1'b0);
    i2c_stop();
    check("R5 sda released after stop", sda_oe, 1'b0);
  endtask

  // R7 R8 R9: all voltage codes with forced tone and high limit
  task automatic t_vsel();
    for (int k = 0; k < 4; k++) begin
      logic vs, ll;
      vs = k[0]; ll = k[1];
      write_reg(8'h2C | {6'd0, ll, vs}, "R7 write");
      check("R7 voltage code", vsel_code, {vs, ll});
      check("R8 tone forced on", tone_out, 1'b1);
      check("R9 ilim high", ilim_hi, 1'b1);
    end
  endtask

  // R10 R11: enable clear overrides every field
  task automatic t_disable();
    write_reg(8'h1F, "R10 write");
    tone = 1'b1; #1ns;
    check("R10 outputs gated", {ch1_en, tone_out, ilim_hi, dyn_ilim, vsel_code}, 6'd0);
    check("R11 ch2 independent", ch2_en, 1'b1);
    tone = 1'b0;
  endtask

  // R12 R3: status captured at byte load
  task automatic t_status();
    logic a;
    logic [7:0] v;
    write_reg(8'h20, "R12 write");
    olf = 1'b1; repeat (10) @(negedge clk);
    i2c_start(); wr_byte(AR, a);
    rbit(v[7]);
    olf = 1'b0;
    for (int i = 6; i >= 0; i--) rbit(v[i]);
    wbit(1'b1);
    i2c_stop();
    check("R12 status held within byte", v, 8'h60);
    i2c_start(); wr_byte(AR, a); rd_byte(1'b0, v); i2c_stop();
    check("R3 live overload bit", v, 8'h20);
  endtask

  // R6: power loss clears registers and pointer
  task automatic t_pwr();
    logic a;
    logic [7:0] v;
    write_reg(8'hC1, "R6 write");
    pwr_ok = 1'b0; repeat (10) @(negedge clk);
    check("R6 outputs cleared", {ch1_en, ch2_en, vsel_code}, 4'd0);
    pwr_ok = 1'b1; otf = 1'b0; olf = 1'b0; repeat (10) @(negedge clk);
    i2c_start(); wr_byte(AR, a);
    rd_byte(1'b1, v); check("R6 first read from cleared A", v, 8'h00);
    rd_byte(1'b0, v); check("R6 cleared B", v, 8'h80);
    i2c_stop();
  endtask

  initial begin
    #800us;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwr_ok = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    otf = 1'b0; olf = 1'b0; tone = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R6 reset sda", sda_oe, 1'b0);
    check("R10 reset outputs", {ch1_en, ch2_en, tone_out, ilim_hi, dyn_ilim, vsel_code}, 7'd0);
    t_addr();
    t_write();
    t_read();
    t_vsel();
    t_disable();
    t_status();
    t_pwr();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule